// File: doc/BRIEF.md
# Reloading Overflow Timer with Sixteen-Step PWM

This block is a 16-bit up-counter for periodic events. It advances only on cycles where two clock-enable inputs are both high. A fast enable sets the base rate, and a slow enable gates it, so holding the fast enable high makes the slow one set the rate. Software writes a start value. The counter runs from that value to the all-ones count. On the next enabled tick it loads the start value again and raises a one-cycle interrupt pulse.

Each overflow also steps a 4-bit phase counter, so one PWM period spans sixteen overflow periods. A 4-bit duty field in the control word sets how many of those sixteen periods drive the PWM pin high. The pin is high while the phase is below the duty value.

The register port has two write addresses: the start value and the control word. It has two read selections: the live count and the control word. The reload value itself cannot be read back.

Top module: `ovf_pwm_timer`

## Requirements
- R1: After reset the count, the hidden reload value, the duty field and the PWM phase are all zero, `irq_pulse` is low and `pwm_out` is low.
- R2: A write with `wr_sel`=0 loads `wr_data` into both the count and the reload value at that clock edge, and it overrides any tick in the same cycle.
- R3: With `rd_sel`=0, `rd_data` shows the live count. With `rd_sel`=1, `rd_data` shows the control word: the duty field in bits [9:6] and every other bit zero.
- R4: The counter advances only when `tick_fast` and `tick_slow` are both high in the same cycle. Either one alone leaves the count unchanged.
- R5: An enabled tick with the count below 0xFFFF raises the count by exactly one.
- R6: An enabled tick with the count at 0xFFFF loads the reload value into the count. `irq_pulse` is then high for exactly the one following clock cycle.
- R7: `irq_pulse` is low in every cycle that does not follow an overflow tick.
- R8: Each overflow adds one to the 4-bit phase, which wraps after 16. `pwm_out` is high while the phase is less than the duty field, which gives a duty of duty/16 measured in overflow periods.
- R9: With a duty field of 0, `pwm_out` stays low through the whole sixteen-overflow period.
- R10: A write with `wr_sel`=1 updates only the duty field from `wr_data[9:6]`. The other bits of the data are ignored, and the count, the reload value and the phase are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 start value, 1 control word |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Read selection: 0 live count, 1 control word |
| rd_data | output | 16 | Read data |
| tick_fast | input | 1 | High-rate count enable |
| tick_slow | input | 1 | Low-rate count enable that gates the high-rate one |
| irq_pulse | output | 1 | One-cycle overflow interrupt |
| pwm_out | output | 1 | Pulse-width-modulated output |

## Verification
The hardest states to reach from the ports are a full sixteen-overflow PWM period and the wrap of the phase counter. From a random start value, a single overflow can take up to 65536 enabled ticks. To get there, the stimulus loads start values of 0xFFFF, which overflow on every tick, and start values in the top sixteen counts. It also drives the two enables with independent random patterns, so gated-off cycles fall between and on top of overflow ticks. Further directed cases cover a start-value write and a tick in the same cycle, and a control write whose bits outside the duty field are all ones.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned PHASE_W  = 4;
  localparam int unsigned DUTY_LSB = 6;
  localparam int unsigned DUTY_MSB = DUTY_LSB + PHASE_W - 1;

  typedef enum logic {
    SEL_VALUE = 1'b0,
    SEL_CTRL  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/tmr_tick_gate.sv
module tmr_tick_gate #(
  parameter int unsigned N_SRC = 2
) (
  input  logic [N_SRC-1:0] src_en,
  output logic             tick
);
  logic [N_SRC:0] chain;

  assign chain[0] = 1'b1;

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_and
      assign chain[g+1] = chain[g] & src_en[g];
    end
  endgenerate

  assign tick = chain[N_SRC];
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  input  logic         tick,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] reload_q,
  output logic         ovf,
  output logic         irq_q
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_d;
  logic [W-1:0] reload_d;
  logic         cnt_en;

  assign ovf = tick & ~ld_en & (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d    = cnt_q;
    reload_d = reload_q;
    cnt_en   = 1'b0;
    if (ld_en) begin
      cnt_d    = ld_val;
      reload_d = ld_val;
      cnt_en   = 1'b1;
    end else if (tick) begin
      cnt_en = 1'b1;
      cnt_d  = ovf ? reload_q : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= ovf;
      if (cnt_en) cnt_q <= cnt_d;
      if (ld_en)  reload_q <= reload_d;
    end
  end
endmodule

// File: rtl/tmr_pwm.sv
module tmr_pwm #(
  parameter int unsigned PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          duty_we,
  input  logic [PW-1:0] duty_val,
  output logic [PW-1:0] duty_q,
  output logic [PW-1:0] phase_q,
  output logic          pwm
);
  logic [PW-1:0] phase_d;

  always_comb begin
    phase_d = phase_q;
    if (step) phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      duty_q  <= '0;
    end else begin
      if (step)    phase_q <= phase_d;
      if (duty_we) duty_q  <= duty_val;
    end
  end

  assign pwm = (phase_q < duty_q);
endmodule

// File: rtl/ovf_pwm_timer.sv
module ovf_pwm_timer
  import tmr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [15:0] wr_data,
  input  logic        rd_sel,
  output logic [15:0] rd_data,
  input  logic        tick_fast,
  input  logic        tick_slow,
  output logic        irq_pulse,
  output logic        pwm_out
);
  logic               tick;
  logic               ovf;
  logic               ld_en;
  logic               duty_we;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   reload_q;
  logic [PHASE_W-1:0] duty_q;
  logic [PHASE_W-1:0] phase_q;
  logic [CNT_W-1:0]   ctrl_word;

  assign ld_en   = wr_en & (reg_sel_e'(wr_sel) == SEL_VALUE);
  assign duty_we = wr_en & (reg_sel_e'(wr_sel) == SEL_CTRL);

  tmr_tick_gate #(.N_SRC(2)) u_gate (
    .src_en ({tick_slow, tick_fast}),
    .tick   (tick)
  );

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en    (ld_en),
    .ld_val   (wr_data),
    .tick     (tick),
    .cnt_q    (cnt_q),
    .reload_q (reload_q),
    .ovf      (ovf),
    .irq_q    (irq_pulse)
  );

  tmr_pwm #(.PW(PHASE_W)) u_pwm (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (ovf),
    .duty_we  (duty_we),
    .duty_val (wr_data[DUTY_MSB:DUTY_LSB]),
    .duty_q   (duty_q),
    .phase_q  (phase_q),
    .pwm      (pwm_out)
  );

  always_comb begin
    ctrl_word                    = '0;
    ctrl_word[DUTY_MSB:DUTY_LSB] = duty_q;
  end

  assign rd_data = (reg_sel_e'(rd_sel) == SEL_CTRL) ? ctrl_word : cnt_q;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               wr_sel,
  input logic [CNT_W-1:0]   wr_data,
  input logic               tick_fast,
  input logic               tick_slow,
  input logic               irq_pulse,
  input logic               pwm_out,
  input logic [CNT_W-1:0]   cnt_q,
  input logic [CNT_W-1:0]   reload_q,
  input logic [PHASE_W-1:0] duty_q,
  input logic [PHASE_W-1:0] phase_q
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic ld;
  logic en;
  assign ld = wr_en & ~wr_sel;
  assign en = tick_fast & tick_slow;

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt_q == $past(wr_data)) && (reload_q == $past(wr_data)));

  assert_gate_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ld) |=> $stable(cnt_q));

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ld && cnt_q != TOP) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ld && cnt_q == TOP) |=> (cnt_q == $past(reload_q)) && irq_pulse);

  assert_quiet_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && !ld && cnt_q == TOP) |=> !irq_pulse);

  assert_phase_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pulse |-> $stable(phase_q));

  assert_zero_duty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q == '0) |-> !pwm_out);

  assert_ctrl_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> duty_q == $past(wr_data[DUTY_MSB:DUTY_LSB]));
endmodule

bind ovf_pwm_timer tmr_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .tick_fast (tick_fast),
  .tick_slow (tick_slow),
  .irq_pulse (irq_pulse),
  .pwm_out   (pwm_out),
  .cnt_q     (cnt_q),
  .reload_q  (reload_q),
  .duty_q    (duty_q),
  .phase_q   (phase_q)
);

// File: tb/ovf_pwm_timer_tb_top.sv
`timescale 1ns/1ps
module ovf_pwm_timer_tb_top;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        wr_sel;
  logic [15:0] wr_data;
  logic        rd_sel;
  logic [15:0] rd_data;
  logic        tick_fast;
  logic        tick_slow;
  logic        irq_pulse;
  logic        pwm_out;

  int n_chk;
  int n_bad;
  bit finished;

  logic [15:0] m_cnt;
  logic [15:0] m_rel;
  logic [3:0]  m_duty;
  logic [3:0]  m_phase;
  logic        m_irq;
  string       m_tag;

  ovf_pwm_timer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .rd_sel    (rd_sel),
    .rd_data   (rd_data),
    .tick_fast (tick_fast),
    .tick_slow (tick_slow),
    .irq_pulse (irq_pulse),
    .pwm_out   (pwm_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [15:0] exp_rd(logic rs);
    return rs ? (16'(m_duty) << 6) : m_cnt;
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(m_tag, "rd_data", rd_data, exp_rd(rd_sel));
    chk(m_irq ? "R6" : "R7", "irq_pulse", 16'(irq_pulse), 16'(m_irq));
    chk(m_duty == 4'd0 ? "R9" : "R8", "pwm_out", 16'(pwm_out), 16'(m_phase < m_duty));
  endtask

  task automatic model(bit we, bit sel, logic [15:0] d, bit tf, bit ts);
    m_irq = 1'b0;
    if (we && !sel) begin
      m_cnt = d;
      m_rel = d;
    end else if (tf && ts) begin
      if (m_cnt == 16'hFFFF) begin
        m_cnt   = m_rel;
        m_irq   = 1'b1;
        m_phase = m_phase + 4'd1;
      end else begin
        m_cnt = m_cnt + 16'd1;
      end
    end
    if (we && sel) m_duty = d[9:6];
  endtask

  task automatic cyc(bit we, bit sel, logic [15:0] d, bit tf, bit ts, bit rs, string t);
    @(negedge clk);
    compare();
    wr_en = we; wr_sel = sel; wr_data = d;
    tick_fast = tf; tick_slow = ts; rd_sel = rs;
    model(we, sel, d, tf, ts);
    m_tag = t;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    n_chk = 0; n_bad = 0; finished = 1'b0;
    rst_n = 1'b0; wr_en = 0; wr_sel = 0; wr_data = '0;
    rd_sel = 0; tick_fast = 0; tick_slow = 0;
    m_cnt = '0; m_rel = '0; m_duty = '0; m_phase = '0; m_irq = 0;
    m_tag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state is compared by the first call; R2 start value write
    cyc(1, 0, 16'hFFFD, 0, 0, 0, "R2");
    // R4: each enable alone must not advance
    cyc(0, 0, 16'h0000, 1, 0, 0, "R4");
    cyc(0, 0, 16'h0000, 0, 1, 0, "R4");
    // R5 steps, R6 wrap to start value with pulse
    cyc(0, 0, 16'h0000, 1, 1, 0, "R5");
    cyc(0, 0, 16'h0000, 1, 1, 0, "R5");
    cyc(0, 0, 16'h0000, 1, 1, 0, "R6");
    cyc(0, 0, 16'h0000, 0, 0, 0, "R7");
    // R10: junk outside the duty field, duty 3; R3 reads control word
    cyc(1, 1, 16'hFCFF, 0, 0, 1, "R3");
    cyc(0, 0, 16'h0000, 0, 0, 0, "R10");
    // R2: write wins over a simultaneous tick
    cyc(1, 0, 16'h1234, 1, 1, 0, "R2");
    cyc(1, 0, 16'hFFFF, 0, 0, 0, "R2");
    // R8: overflow on every tick, several full PWM periods at 3/16
    for (int i = 0; i < 40; i++) cyc(0, 0, 16'h0000, 1, 1, i[0], "R8");
    // R9: zero duty over a full period
    cyc(1, 1, 16'hFFFF & ~16'h03C0, 0, 0, 1, "R10");
    for (int i = 0; i < 20; i++) cyc(0, 0, 16'h0000, 1, 1, 0, "R9");
    // Random traffic
    for (int i = 0; i < 6000; i++) begin
      bit we, sel, tf, ts, rs;
      logic [15:0] d;
      we  = ($urandom % 100) < 4;
      sel = $urandom % 2;
      d   = ($urandom % 2) ? (16'hFFF0 | 16'($urandom % 16)) : 16'($urandom);
      tf  = ($urandom % 100) < 75;
      ts  = ($urandom % 100) < 75;
      rs  = ($urandom % 4) == 0;
      cyc(we, sel, d, tf, ts, rs, "R5");
    end
    cyc(0, 0, 16'h0000, 0, 0, 0, "R5");
    @(negedge clk);
    compare();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule